// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit offset into a 20-bit physical byte address by adding it to one of four 16-bit segment bases. Each base is scaled by sixteen before the addition, so a segment covers 64K bytes starting at any 16-byte boundary of a 1 MiB space. The four bases (code, stack, data and extra) sit in a small register file. A write port loads them one at a time.

A requester presents an access kind, an offset and, optionally, an explicit segment choice. The block picks the segment that the access kind implies: code fetch, stack, plain data, or the destination of a string move. A valid override replaces that choice, except on code fetches. The sum appears on a registered output one cycle later, together with a one-cycle valid flag. Address arithmetic wraps at the top of the 20-bit space.

Top module: `seg_addr_gen`

## Requirements
- R1: Four 16-bit segment registers are loaded through the write port when `wr_en` is high. `wr_sel` chooses the register: 00 extra, 01 code, 10 stack, 11 data. A register keeps its value until it is written again.
- R2: The physical address equals the selected segment value times 16 plus the zero-extended offset. For example, segment 08F1h with offset 0100h gives 09010h.
- R3: Without an override, `req_type` chooses the segment: 00 code fetch uses code, 01 stack uses stack, 10 data uses data, 11 string destination uses extra. For example, a code fetch with code segment 3480h and offset 1234h gives 35A34h.
- R4: The sum is taken modulo 2^20 and any carry out of bit 19 is dropped. For example, FFFFh:0010h gives 00000h.
- R5: Reset (`rst_n` low) sets the code segment to FFFFh, sets the other three segments to 0000h, and clears `pa_valid` and `pa_addr`.
- R6: When `ovr_valid` is high on a non-fetch request, `ovr_sel` names the segment with the same encoding as `wr_sel` (00 extra, 01 code, 10 stack, 11 data) in place of the default.
- R7: A code fetch (`req_type` 00) always uses the code segment, whatever `ovr_valid` and `ovr_sel` hold.
- R8: A segment write in the same cycle as a request does not change that request's address, which uses the old value. The new value applies from the next cycle on.
- R9: `pa_valid` is high in the cycle after each cycle with `req_valid` high and is low otherwise. `pa_addr` updates only in those cycles and holds its last value between requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Segment register write strobe |
| wr_sel | input | 2 | Segment register to write |
| wr_data | input | 16 | New segment value |
| req_valid | input | 1 | Address request strobe |
| req_type | input | 2 | Access kind that picks the default segment |
| req_off | input | 16 | Offset within the segment |
| ovr_valid | input | 1 | Explicit segment choice present |
| ovr_sel | input | 2 | Explicitly chosen segment |
| pa_valid | output | 1 | Physical address valid, one cycle per request |
| pa_addr | output | 20 | Registered physical address |

## Verification
The hardest case to reach is a collision: a write to the very segment a request selects, in the same cycle. Only one cycle separates a correct old-value read from a bypassed new value. The directed sequence sets up such a collision on the data segment and then repeats the request alone, so that both values show at the output. A long random phase then mixes writes, overrides and all four access kinds against the bench's own model. Directed cases near the top of the space (FFFFh bases with large offsets) cover the dropped carry.

// File: rtl/seg_pkg.sv
package seg_pkg;

   localparam int NSEG = 4;

   typedef enum logic [1:0] {
      SEG_EXTRA = 2'b00,
      SEG_CODE  = 2'b01,
      SEG_STACK = 2'b10,
      SEG_DATA  = 2'b11
   } seg_id_e;

   typedef enum logic [1:0] {
      ACC_FETCH  = 2'b00,
      ACC_STACK  = 2'b01,
      ACC_DATA   = 2'b10,
      ACC_STRDST = 2'b11
   } acc_kind_e;

   function automatic seg_id_e default_seg(input acc_kind_e kind);
      seg_id_e s;
      case (kind)
         ACC_FETCH:  s = SEG_CODE;
         ACC_STACK:  s = SEG_STACK;
         ACC_DATA:   s = SEG_DATA;
         default:    s = SEG_EXTRA;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile #(
   parameter int          SEG_W    = 16,
   parameter int          NREG     = 4,
   parameter int          CODE_IDX = 1,
   parameter logic [15:0] CODE_RST = 16'hFFFF,
   parameter logic [15:0] DFLT_RST = 16'h0000
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [$clog2(NREG)-1:0]        wr_sel,
   input  logic [SEG_W-1:0]               wr_data,
   output logic [NREG-1:0][SEG_W-1:0]     seg_all
);

   localparam int SEL_W = $clog2(NREG);

   if (SEG_W < 1 || SEG_W > 16) begin : g_bad_segw
      $error("seg_regfile: SEG_W must be 1..16");
   end
   if (CODE_IDX < 0 || CODE_IDX >= NREG) begin : g_bad_code
      $error("seg_regfile: CODE_IDX out of range");
   end

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      localparam logic [SEG_W-1:0] RST_VAL =
         (i == CODE_IDX) ? CODE_RST[SEG_W-1:0] : DFLT_RST[SEG_W-1:0];
      logic hit;
      assign hit = wr_en && (wr_sel == SEL_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            seg_all[i] <= RST_VAL;
         end else if (hit) begin
            seg_all[i] <= wr_data;
         end
      end
   end

endmodule

// File: rtl/seg_select.sv
module seg_select
   import seg_pkg::*;
#(
   parameter int SEG_W = 16
) (
   input  logic [1:0]                 req_type,
   input  logic                       ovr_valid,
   input  logic [1:0]                 ovr_sel,
   input  logic [NSEG-1:0][SEG_W-1:0] seg_all,
   output logic [SEG_W-1:0]           base
);

   acc_kind_e kind;
   seg_id_e   pick;

   assign kind = acc_kind_e'(req_type);

   always_comb begin
      if (kind == ACC_FETCH) begin
         pick = SEG_CODE;
      end else if (ovr_valid) begin
         pick = seg_id_e'(ovr_sel);
      end else begin
         pick = default_seg(kind);
      end
   end

   assign base = seg_all[pick];

endmodule

// File: rtl/seg_adder.sv
module seg_adder #(
   parameter int SEG_W = 16,
   parameter int OFF_W = 16,
   parameter int SHIFT = 4,
   parameter int PA_W  = 20,
   parameter bit SPLIT = 1'b1
) (
   input  logic [SEG_W-1:0] base,
   input  logic [OFF_W-1:0] off,
   output logic [PA_W-1:0]  pa
);

   localparam int HI_W  = PA_W - SHIFT;
   localparam int OHI_W = OFF_W - SHIFT;

   if (PA_W != SEG_W + SHIFT) begin : g_bad_pa
      $error("seg_adder: PA_W must equal SEG_W + SHIFT");
   end
   if (SHIFT < 1 || OFF_W <= SHIFT || OFF_W >= PA_W || OHI_W >= HI_W) begin : g_bad_off
      $error("seg_adder: offset width does not fit the shift");
   end

   if (SPLIT) begin : g_split
      logic [HI_W-1:0] hi_sum;
      assign hi_sum = base + {{(HI_W-OHI_W){1'b0}}, off[OFF_W-1:SHIFT]};
      assign pa     = {hi_sum, off[SHIFT-1:0]};
   end else begin : g_full
      logic [PA_W-1:0] scaled;
      logic [PA_W-1:0] ext_off;
      assign scaled  = {base, {SHIFT{1'b0}}};
      assign ext_off = {{(PA_W-OFF_W){1'b0}}, off};
      assign pa      = scaled + ext_off;
   end

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
   import seg_pkg::*;
#(
   parameter int          SEG_W     = 16,
   parameter int          OFF_W     = 16,
   parameter int          SHIFT     = 4,
   parameter bit          SPLIT_ADD = 1'b1,
   parameter logic [15:0] CODE_RST  = 16'hFFFF,
   parameter logic [15:0] DFLT_RST  = 16'h0000
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [1:0]              wr_sel,
   input  logic [SEG_W-1:0]        wr_data,
   input  logic                    req_valid,
   input  logic [1:0]              req_type,
   input  logic [OFF_W-1:0]        req_off,
   input  logic                    ovr_valid,
   input  logic [1:0]              ovr_sel,
   output logic                    pa_valid,
   output logic [SEG_W+SHIFT-1:0]  pa_addr
);

   localparam int PA_W = SEG_W + SHIFT;

   logic [NSEG-1:0][SEG_W-1:0] seg_all;
   logic [SEG_W-1:0]           base;
   logic [PA_W-1:0]            pa_next;

   seg_regfile #(
      .SEG_W    (SEG_W),
      .NREG     (NSEG),
      .CODE_IDX (int'(SEG_CODE)),
      .CODE_RST (CODE_RST),
      .DFLT_RST (DFLT_RST)
   ) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .seg_all (seg_all)
   );

   seg_select #(
      .SEG_W (SEG_W)
   ) u_sel (
      .req_type  (req_type),
      .ovr_valid (ovr_valid),
      .ovr_sel   (ovr_sel),
      .seg_all   (seg_all),
      .base      (base)
   );

   seg_adder #(
      .SEG_W (SEG_W),
      .OFF_W (OFF_W),
      .SHIFT (SHIFT),
      .PA_W  (PA_W),
      .SPLIT (SPLIT_ADD)
   ) u_add (
      .base (base),
      .off  (req_off),
      .pa   (pa_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pa_valid <= 1'b0;
         pa_addr  <= '0;
      end else begin
         pa_valid <= req_valid;
         if (req_valid) begin
            pa_addr <= pa_next;
         end
      end
   end

endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
   parameter int          SEG_W    = 16,
   parameter int          OFF_W    = 16,
   parameter int          SHIFT    = 4,
   parameter logic [15:0] CODE_RST = 16'hFFFF,
   parameter logic [15:0] DFLT_RST = 16'h0000
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    wr_en,
   input logic [1:0]              wr_sel,
   input logic [SEG_W-1:0]        wr_data,
   input logic                    req_valid,
   input logic [1:0]              req_type,
   input logic [OFF_W-1:0]        req_off,
   input logic                    ovr_valid,
   input logic [1:0]              ovr_sel,
   input logic                    pa_valid,
   input logic [SEG_W+SHIFT-1:0]  pa_addr,
   input logic [3:0][SEG_W-1:0]   seg_all
);

   localparam int PA_W = SEG_W + SHIFT;

   function automatic logic [PA_W-1:0] form(input logic [SEG_W-1:0] s,
                                            input logic [OFF_W-1:0] o);
      logic [PA_W-1:0] a;
      logic [PA_W-1:0] b;
      a = {s, {SHIFT{1'b0}}};
      b = {{(PA_W-OFF_W){1'b0}}, o};
      return a + b;
   endfunction

   // Independent selection: fetch -> slot 1, else override, else table.
   function automatic logic [1:0] chosen(input logic [1:0] t, input logic ov,
                                         input logic [1:0] os);
      if (t == 2'b00) return 2'b01;
      if (ov)         return os;
      return (t == 2'b01) ? 2'b10 : (t == 2'b10) ? 2'b11 : 2'b00;
   endfunction

   logic [SEG_W-1:0] sel_val;
   logic [SEG_W-1:0] wr_target;
   assign sel_val   = seg_all[chosen(req_type, ovr_valid, ovr_sel)];
   assign wr_target = seg_all[wr_sel];

   // R2 R3 R6 R8: address from the pre-edge segment value
   p_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> pa_addr == form($past(sel_val), $past(req_off)));

   // R7: fetch takes the code segment regardless of override inputs
   p_fetch_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_type == 2'b00) |=> pa_addr == form($past(seg_all[1]), $past(req_off)));

   // R9: one valid pulse per request, address held between requests
   p_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> pa_valid);
   p_novalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !pa_valid);
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(pa_addr));

   // R1: write lands, registers otherwise hold
   p_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> $past(wr_target) == $past(seg_all[wr_sel]) && seg_all[$past(wr_sel)] == $past(wr_data));
   p_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(seg_all));

   // R5: reset values
   p_reset_r5: assert property (@(posedge clk)
      !rst_n |=> (seg_all[1] == CODE_RST[SEG_W-1:0] && seg_all[0] == DFLT_RST[SEG_W-1:0]
                  && seg_all[2] == DFLT_RST[SEG_W-1:0] && seg_all[3] == DFLT_RST[SEG_W-1:0]
                  && !pa_valid && pa_addr == '0));

endmodule

bind seg_addr_gen seg_addr_gen_chk #(
   .SEG_W    (SEG_W),
   .OFF_W    (OFF_W),
   .SHIFT    (SHIFT),
   .CODE_RST (CODE_RST),
   .DFLT_RST (DFLT_RST)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_sel    (wr_sel),
   .wr_data   (wr_data),
   .req_valid (req_valid),
   .req_type  (req_type),
   .req_off   (req_off),
   .ovr_valid (ovr_valid),
   .ovr_sel   (ovr_sel),
   .pa_valid  (pa_valid),
   .pa_addr   (pa_addr),
   .seg_all   (seg_all)
);

// File: tb/seg_addr_gen_bench.sv
module seg_addr_gen_bench;

   localparam int CLK_PERIOD = 10;
   localparam int PA_MASK    = 20'hFFFFF;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = '0;
   logic [15:0] wr_data = '0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_type = '0;
   logic [15:0] req_off = '0;
   logic        ovr_valid = 1'b0;
   logic [1:0]  ovr_sel = '0;
   logic        pa_valid;
   logic [19:0] pa_addr;

   int    checks = 0;
   int    failures = 0;
   bit    started = 1'b0;
   bit    done = 1'b0;
   string tag = "R5";
   string exp_tag = "R5";

   int seg_m [4];
   bit exp_valid;
   int exp_addr;

   always #(CLK_PERIOD/2) clk = ~clk;

   seg_addr_gen u_seg_addr_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_sel    (wr_sel),
      .wr_data   (wr_data),
      .req_valid (req_valid),
      .req_type  (req_type),
      .req_off   (req_off),
      .ovr_valid (ovr_valid),
      .ovr_sel   (ovr_sel),
      .pa_valid  (pa_valid),
      .pa_addr   (pa_addr)
   );

   function automatic int pick(input int t, input bit ov, input int os);
      if (t == 0) return 1;
      if (ov)     return os;
      case (t)
         1: return 2;
         2: return 3;
         default: return 0;
      endcase
   endfunction

   // Reference model, evaluated on each rising edge
   always @(posedge clk) begin
      started <= 1'b1;
      if (!rst_n) begin
         seg_m[0] <= 0; seg_m[1] <= 16'hFFFF; seg_m[2] <= 0; seg_m[3] <= 0;
         exp_valid <= 1'b0;
         exp_addr  <= 0;
         exp_tag   <= "R5";
      end else begin
         exp_valid <= req_valid;
         exp_tag   <= tag;
         if (req_valid)
            exp_addr <= ((seg_m[pick(int'(req_type), ovr_valid, int'(ovr_sel))] * 16)
                         + int'(req_off)) & PA_MASK;
         if (wr_en) seg_m[wr_sel] <= int'(wr_data);
      end
   end

   // Per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (started && !done) begin
         checks++;
         if (pa_valid !== exp_valid || int'(pa_addr) != exp_addr) begin
            failures++;
            $display("FAIL %s R9 model: valid=%0b addr=%05h expected valid=%0b addr=%05h",
                     exp_tag, pa_valid, pa_addr, exp_valid, exp_addr[19:0]);
         end
      end
   end

   task automatic lit(input string r, input logic [19:0] want);
      checks++;
      if (pa_valid !== 1'b1 || pa_addr !== want) begin
         failures++;
         $display("FAIL %s: valid=%0b addr=%05h expected valid=1 addr=%05h",
                  r, pa_valid, pa_addr, want);
      end
   endtask

   task automatic step(input bit w, input logic [1:0] ws, input logic [15:0] wd,
                       input bit rv, input logic [1:0] rt, input logic [15:0] ro,
                       input bit ov, input logic [1:0] os);
      wr_en = w; wr_sel = ws; wr_data = wd;
      req_valid = rv; req_type = rt; req_off = ro;
      ovr_valid = ov; ovr_sel = os;
      @(negedge clk);
      wr_en = 1'b0; req_valid = 1'b0; ovr_valid = 1'b0;
   endtask

   task automatic wr(input logic [1:0] s, input logic [15:0] d);
      step(1'b1, s, d, 1'b0, 2'b00, 16'h0, 1'b0, 2'b00);
   endtask

   task automatic rq(input logic [1:0] t, input logic [15:0] o,
                     input bit ov, input logic [1:0] os);
      step(1'b0, 2'b00, 16'h0, 1'b1, t, o, ov, os);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      checks++;
      if (pa_valid !== 1'b0 || pa_addr !== 20'h0) begin
         failures++;
         $display("FAIL R5 reset: valid=%0b addr=%05h expected valid=0 addr=00000", pa_valid, pa_addr);
      end
      rst_n = 1'b1;
      @(negedge clk);

      tag = "R5"; rq(2'b00, 16'h0000, 1'b0, 2'b00); lit("R5 code reset FFFF", 20'hFFFF0);
      rq(2'b01, 16'h0000, 1'b0, 2'b00);             lit("R5 stack reset 0", 20'h00000);

      tag = "R2"; wr(2'b11, 16'h08F1);
      rq(2'b10, 16'h0100, 1'b0, 2'b00);             lit("R2 08F1:0100", 20'h09010);

      tag = "R3"; wr(2'b01, 16'h3480);
      rq(2'b00, 16'h1234, 1'b0, 2'b00);             lit("R3 fetch 3480:1234", 20'h35A34);
      wr(2'b00, 16'h2000);
      rq(2'b11, 16'h0005, 1'b0, 2'b00);             lit("R3 string dest extra", 20'h20005);

      tag = "R4"; wr(2'b10, 16'hFFFF);
      rq(2'b01, 16'h0010, 1'b0, 2'b00);             lit("R4 FFFF:0010 wrap", 20'h00000);
      rq(2'b01, 16'hFFFF, 1'b0, 2'b00);             lit("R4 FFFF:FFFF wrap", 20'h0FFEF);

      tag = "R6";
      rq(2'b10, 16'h0005, 1'b1, 2'b00);             lit("R6 data over extra", 20'h20005);
      rq(2'b01, 16'h0003, 1'b1, 2'b11);             lit("R6 stack over data", 20'h08F13);

      tag = "R7";
      rq(2'b00, 16'h0000, 1'b1, 2'b10);             lit("R7 fetch ignores override", 20'h34800);

      tag = "R8";
      step(1'b1, 2'b11, 16'h1111, 1'b1, 2'b10, 16'h0000, 1'b0, 2'b00);
      lit("R8 same-cycle write uses old", 20'h08F10);
      rq(2'b10, 16'h0000, 1'b0, 2'b00);             lit("R8 next cycle uses new", 20'h11110);

      tag = "R9"; @(negedge clk);
      checks++;
      if (pa_valid !== 1'b0 || pa_addr !== 20'h11110) begin
         failures++;
         $display("FAIL R9 idle: valid=%0b addr=%05h expected valid=0 addr=11110", pa_valid, pa_addr);
      end

      tag = "R1";
      for (int i = 0; i < 600; i++) begin
         step(1'($urandom_range(0, 1)), 2'($urandom), 16'($urandom),
              1'($urandom_range(0, 2) != 0), 2'($urandom), 16'($urandom),
              1'($urandom_range(0, 1)), 2'($urandom));
      end
      @(negedge clk);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule